// File: doc/BRIEF.md
# Wide-to-Narrow Three-Slice FIFO

This block is a single-clock FIFO whose write side takes wide words and whose read side hands them out as narrow pieces, each a third of the write width. With the default parameters, 15-bit words go in and 5-bit pieces come out. Every storage entry holds one complete wide word. The read side keeps a small slice counter that steps through the three pieces of the word at the head of the queue. The storage address is never divided by three.

Both sides use a valid/ready handshake. A producer offers a wide word with `in_valid` and `in_data`, and the word is taken on any clock edge where `in_ready` is also high. A consumer takes one narrow piece on any edge where `out_valid` and `out_take` are both high. The head entry is released, and the read pointer moves on, only when its last piece is taken. Capacity is counted in whole wide words, and the depth is a parameter.

Top module: `slice_fifo`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: The three pieces of a stored word come out least-significant first: bits [4:0], then bits [9:5], then bits [14:10] (with the default widths, piece k is bits [5k+4:5k]).
- R3: The head word stays at the output for exactly three accepted reads. The read after the third one returns piece 0 of the next stored word.
- R4: While `out_valid` is 1 and `out_take` is 0, `out_valid` stays 1 and `out_data` keeps its value on the next cycle.
- R5: Once DEPTH wide words are held, `in_ready` is 0. A word offered while `in_ready` is 0 is not stored and never appears at the output.
- R6: `out_valid` stays 1 until the last piece of the last stored word has been taken. Taking only one or two of its pieces does not clear it.
- R7: A write and a read in the same cycle both take effect when the FIFO is neither full nor empty.
- R8: Words come out in the order they were accepted, with no piece lost or repeated, under any mix of handshakes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Wide word offered |
| in_ready | output | 1 | FIFO can accept a wide word |
| in_data | input | NARROW_W*3 | Wide word |
| out_valid | output | 1 | A narrow piece is available |
| out_take | input | 1 | Consumer accepts the current piece |
| out_data | output | NARROW_W | Current narrow piece |

## Verification
The checker tests on every cycle that a stalled output holds its value, that the slice counter advances by one on each accepted read and returns to zero after the third piece with the read index moving only at that point, that the counter is zero whenever the FIFO is empty, and that a full FIFO always offers data. Slice order, rejection of writes while full, same-cycle write and read, and end-to-end ordering depend on data values across many cycles. Only the bench scenarios can show these: a reference queue driven by directed corner cases and a long seeded random handshake run.

// File: rtl/slice_fifo.sv
module slice_fifo #(
  parameter int NARROW_W = 5,
  parameter int DEPTH    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [NARROW_W*3-1:0] in_data,
  output logic                  out_valid,
  input  logic                  out_take,
  output logic [NARROW_W-1:0]   out_data
);
  localparam int RATIO  = 3;
  localparam int WIDE_W = NARROW_W * RATIO;
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SW     = $clog2(RATIO);

  logic [WIDE_W-1:0] store [DEPTH];
  logic [AW-1:0]     widx, ridx;
  logic              wwrap, rwrap;
  logic [SW-1:0]     slc;
  logic              full, empty, wr_go, rd_go, last_slc;
  logic [WIDE_W-1:0] head;

  assign empty     = (widx == ridx) && (wwrap == rwrap);
  assign full      = (widx == ridx) && (wwrap != rwrap);
  assign in_ready  = !full;
  assign out_valid = !empty;
  assign wr_go     = in_valid && !full;
  assign rd_go     = out_take && !empty;
  assign last_slc  = (slc == SW'(RATIO - 1));
  assign head      = store[ridx];

  always_comb begin
    out_data = '0;
    for (int k = 0; k < RATIO; k++)
      if (slc == SW'(k)) out_data = head[k*NARROW_W +: NARROW_W];
  end

  always_ff @(posedge clk)
    if (wr_go) store[widx] <= in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      widx  <= '0;
      wwrap <= 1'b0;
    end else if (wr_go) begin
      if (widx == AW'(DEPTH - 1)) begin
        widx  <= '0;
        wwrap <= !wwrap;
      end else begin
        widx <= widx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ridx  <= '0;
      rwrap <= 1'b0;
      slc   <= '0;
    end else if (rd_go) begin
      if (last_slc) begin
        slc <= '0;
        if (ridx == AW'(DEPTH - 1)) begin
          ridx  <= '0;
          rwrap <= !rwrap;
        end else begin
          ridx <= ridx + 1'b1;
        end
      end else begin
        slc <= slc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/slice_fifo_chk.sv
module slice_fifo_chk #(
  parameter int NARROW_W = 5,
  parameter int AW       = 3,
  parameter int SW       = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_take,
  input logic [NARROW_W-1:0] out_data,
  input logic [SW-1:0]       slc,
  input logic [AW-1:0]       ridx
);
  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_take |=> out_valid && $stable(out_data));
  // R3
  slice_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_take && (slc != SW'(2)) |=> (slc == $past(slc) + 1'b1) && $stable(ridx));
  // R3
  slice_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_take && (slc == SW'(2)) |=> (slc == '0) && !$stable(ridx));
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_take) |=> $stable(slc) && $stable(ridx));
  // R6
  empty_slice_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> slc == '0);
  // R5
  full_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid);
endmodule

bind slice_fifo slice_fifo_chk #(.NARROW_W(NARROW_W), .AW(AW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_take(out_take), .out_data(out_data), .slc(slc), .ridx(ridx)
);

// File: tb/test_slice_fifo.sv
`timescale 1ns/1ps
module test_slice_fifo;
  localparam int NW = 5;
  localparam int WW = NW * 3;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_take = 1'b0;
  logic [WW-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [NW-1:0] out_data;

  int checks = 0;
  int fails = 0;
  logic [WW-1:0] q[$];
  int sidx = 0;

  always #2 clk = !clk;

  slice_fifo #(.NARROW_W(NW), .DEPTH(DEPTH)) i_slice_fifo (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_take(out_take), .out_data(out_data)
  );

  function automatic logic [NW-1:0] piece(logic [WW-1:0] w, int k);
    return w[k*NW +: NW];
  endfunction

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic wv, logic [WW-1:0] wd, logic rv);
    logic wfire, rfire;
    @(negedge clk);
    in_valid = wv; in_data = wd; out_take = rv;
    #1;
    cmp(tag, "out_valid", 32'(out_valid), 32'(q.size() > 0));
    cmp(tag, "in_ready", 32'(in_ready), 32'(q.size() < DEPTH));
    if (q.size() > 0) cmp(tag, "out_data", 32'(out_data), 32'(piece(q[0], sidx)));
    wfire = wv && (q.size() < DEPTH);
    rfire = rv && (q.size() > 0);
    @(posedge clk);
    if (rfire) begin
      if (sidx == 2) begin sidx = 0; void'(q.pop_front()); end
      else sidx++;
    end
    if (wfire) q.push_back(wd);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    step("R1", 0, '0, 0);
    // R2 R4 R3: one word, stalls between pieces, then next word
    step("R2", 1, 15'h7ABC, 0);
    step("R2", 1, 15'h1234, 1);
    step("R4", 0, '0, 0);
    step("R4", 0, '0, 0);
    step("R2", 0, '0, 1);
    step("R2", 0, '0, 1);
    step("R3", 0, '0, 1);
    for (int i = 0; i < 3; i++) step("R3", 0, '0, 1);
    step("R6", 0, '0, 0);
    // R6: partial consumption keeps valid
    step("R6", 1, 15'h5555, 0);
    step("R6", 0, '0, 1);
    step("R6", 0, '0, 1);
    step("R6", 0, '0, 0);
    step("R6", 0, '0, 1);
    step("R6", 0, '0, 0);
    // R5: fill, offer while full, drain
    for (int i = 0; i < DEPTH; i++) step("R5", 1, WW'(16'h0101 * (i + 1)), 0);
    step("R5", 1, 15'h7FFF, 0);
    step("R5", 1, 15'h7FFF, 1);
    for (int i = 0; i < DEPTH * 3 + 2; i++) step("R5", 0, '0, 1);
    // R7: simultaneous write and read with data present
    step("R7", 1, 15'h0F0F, 0);
    for (int i = 0; i < 30; i++) step("R7", 1, WW'($urandom), 1);
    for (int i = 0; i < 40; i++) step("R7", 0, '0, 1);
    // R8: random handshakes
    for (int i = 0; i < 4000; i++)
      step("R8", ($urandom % 3) != 0, WW'($urandom), ($urandom % 4) != 0);
    for (int i = 0; i < DEPTH * 3 + 4; i++) step("R8", 0, '0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule